// File: doc/BRIEF.md
# Eight-Source Interrupt Status Unit

This block gathers single-cycle event pulses from a serial flash controller core into sticky raw flags, one per source. A mask register decides which flags may reach the single interrupt line; a flag whose mask bit is one is still recorded and stays readable. Software sees four register views through simple read and write strobes: the raw flags, the mask, a write-only clear view in which each written one removes a flag, and the masked status, which is raw AND NOT mask.

Raw flags are never removed by anything other than an explicit clear write or the power-on reset. A controller-level recovery of its state machine or FIFO therefore leaves pending events visible until software acknowledges them. The interrupt output is the OR of the masked status bits, taken through a register.

Source order on `evt_i` (bit: meaning): 0 receive FIFO full, 1 receive underflow, 2 transmit overflow, 3 transmit FIFO empty, 4 transfer finished, 5 bus error, 6 non-SPI protocol error, 7 DMA done.

Top module: `flash_irq_status`

## Requirements
- R1: On synchronous reset all raw flags are 0, the mask is all ones, `irq_o` is 0 and `rd_data` is 0.
- R2: A one on `evt_i[k]` at a clock edge sets raw flag k at that edge, whatever mask bit k holds.
- R3: A raw flag stays set on every later edge until a clear write carries a one in its bit position.
- R4: A clear write (`wr_sel` = 2) removes exactly the flags whose `wr_data` bit is 1; bits written as 0 leave their flags unchanged.
- R5: When an event and a clear write hit the same bit in one cycle, the flag is set after that edge.
- R6: Reading `rd_sel` = 3 returns raw AND NOT mask; reading `rd_sel` = 0 returns the raw flags.
- R7: A write with `wr_sel` = 1 loads the mask from `wr_data`, and reading `rd_sel` = 1 returns it; a mask bit of 1 keeps its source off `irq_o`.
- R8: `irq_o` after an edge equals the OR of (raw AND NOT mask) as held just before that edge.
- R9: Reading `rd_sel` = 2 returns 0; writes with `wr_sel` = 0 or 3 change neither the flags nor the mask.
- R10: `rd_data` is loaded at the edge where `rd_en` is 1 with the view selected before that edge, and holds its value on edges where `rd_en` is 0.
- R11: Writing all ones to the mask keeps `irq_o` at 0 even while all eight raw flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write view: 0 raw, 1 mask, 2 clear, 3 masked status |
| wr_data | input | N | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read view, same encoding as `wr_sel` |
| rd_data | output | N | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default of eight sources, so random event vectors, masks and clear patterns cover every bit position and both flag states of each in one run. With eight bits a random mix of sparse events and wide clears regularly produces same-cycle event and clear collisions on one bit, and the all-ones mask case can be combined with every source pending. Directed steps add the reset state, writes to the read-only views and read hold cycles.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  // Register view selector shared by read and write strobes.
  typedef enum logic [1:0] {
    VIEW_RAW    = 2'd0,
    VIEW_MASK   = 2'd1,
    VIEW_CLEAR  = 2'd2,
    VIEW_MASKED = 2'd3
  } view_sel_e;

  // Source positions on the event vector.
  localparam int SRC_RX_FULL   = 0;
  localparam int SRC_RX_UNDER  = 1;
  localparam int SRC_TX_OVER   = 2;
  localparam int SRC_TX_EMPTY  = 3;
  localparam int SRC_XFER_DONE = 4;
  localparam int SRC_BUS_ERR   = 5;
  localparam int SRC_PROTO_ERR = 6;
  localparam int SRC_DMA_DONE  = 7;
  localparam int SRC_COUNT     = 8;

endpackage

// File: rtl/fis_flag_bank.sv
module fis_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  // One sticky flag per source; a set beats a clear in the same cycle.
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[k] <= 1'b0;
      end else if (set_i[k]) begin
        flag_q[k] <= 1'b1;
      end else if (clr_i[k]) begin
        flag_q[k] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fis_mask_reg.sv
module fis_mask_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (we_i) begin
      mask_q <= wdata_i;
    end
  end

endmodule

// File: rtl/fis_irq_gen.sv
module fis_irq_gen #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] masked_o,
  output logic         irq_q
);

  always_comb begin
    masked_o = raw_i & ~mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |masked_o;
    end
  end

endmodule

// File: rtl/fis_readback.sv
module fis_readback
  import flash_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en_i,
  input  view_sel_e    sel_i,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] masked_i,
  output logic [N-1:0] rdata_q
);

  logic [N-1:0] view_d;

  always_comb begin
    unique case (sel_i)
      VIEW_RAW:    view_d = raw_i;
      VIEW_MASK:   view_d = mask_i;
      VIEW_MASKED: view_d = masked_i;
      default:     view_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= view_d;
    end
  end

endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
#(
  parameter int N = SRC_COUNT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [N-1:0] wr_data,
  input  logic         rd_en,
  input  logic [1:0]   rd_sel,
  output logic [N-1:0] rd_data,
  output logic         irq_o
);

  view_sel_e    wsel;
  view_sel_e    rsel;
  logic         mask_we;
  logic [N-1:0] clr_vec;
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] masked;

  always_comb begin
    wsel    = view_sel_e'(wr_sel);
    rsel    = view_sel_e'(rd_sel);
    mask_we = wr_en && (wsel == VIEW_MASK);
    clr_vec = (wr_en && (wsel == VIEW_CLEAR)) ? wr_data : '0;
  end

  fis_flag_bank #(.N(N)) flags_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (evt_i),
    .clr_i  (clr_vec),
    .flag_q (raw_q)
  );

  fis_mask_reg #(.N(N)) mask_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (mask_we),
    .wdata_i (wr_data),
    .mask_q  (mask_q)
  );

  fis_irq_gen #(.N(N)) irq_i (
    .clk      (clk),
    .rst      (rst),
    .raw_i    (raw_q),
    .mask_i   (mask_q),
    .masked_o (masked),
    .irq_q    (irq_o)
  );

  fis_readback #(.N(N)) rb_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en_i  (rd_en),
    .sel_i    (rsel),
    .raw_i    (raw_q),
    .mask_i   (mask_q),
    .masked_i (masked),
    .rdata_q  (rd_data)
  );

endmodule

// File: rtl/flash_irq_status_chk.sv
module flash_irq_status_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] evt_i,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [N-1:0] wr_data,
  input logic         rd_en,
  input logic [N-1:0] rd_data,
  input logic         irq_o,
  input logic [N-1:0] raw_q,
  input logic [N-1:0] mask_q
);

  logic         clr_wr;
  logic [N-1:0] clr_bits;

  always_comb begin
    clr_wr   = wr_en && (wr_sel == 2'd2);
    clr_bits = clr_wr ? wr_data : '0;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (raw_q == '0 && mask_q == '1 && !irq_o && rd_data == '0));

  // R2, R5: an event always leaves its flag set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R3: without a clear write no flag drops
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R4: a flag drops only where a one was written
  a_r4_clear_only_ones: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (($past(raw_q) & ~raw_q & ~$past(clr_bits)) == '0));

  // R8
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(raw_q & ~mask_q))));

  // R10
  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

bind flash_irq_status flash_irq_status_chk #(.N(N)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .evt_i   (evt_i),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .mask_q  (mask_q)
);

// File: tb/flash_irq_status_tb_top.sv
`timescale 1ns/1ps
module flash_irq_status_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_i = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [N-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = 2'd0;
  logic [N-1:0] rd_data;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [N-1:0] raw_m;
  logic [N-1:0] mask_m;
  logic [N-1:0] rd_m;
  logic         irq_m;

  always #2.5 clk = ~clk;

  flash_irq_status #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_o(irq_o)
  );

  function automatic logic [N-1:0] f_view(input logic [1:0] sel,
                                          input logic [N-1:0] raw,
                                          input logic [N-1:0] msk);
    case (sel)
      2'd0:    return raw;
      2'd1:    return msk;
      2'd3:    return raw & ~msk;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] f_next_raw(input logic [N-1:0] raw,
                                              input logic [N-1:0] evt,
                                              input logic wen,
                                              input logic [1:0] sel,
                                              input logic [N-1:0] wd);
    logic [N-1:0] clr;
    clr = (wen && sel == 2'd2) ? wd : '0;
    return (raw & ~clr) | evt;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic step(input logic [N-1:0] evt, input logic wen,
                      input logic [1:0] wsel, input logic [N-1:0] wd,
                      input logic ren, input logic [1:0] rsel,
                      input string rtag, input string itag);
    evt_i = evt; wr_en = wen; wr_sel = wsel; wr_data = wd;
    rd_en = ren; rd_sel = rsel;
    irq_m = |(raw_m & ~mask_m);
    if (ren) rd_m = f_view(rsel, raw_m, mask_m);
    raw_m = f_next_raw(raw_m, evt, wen, wsel, wd);
    if (wen && wsel == 2'd1) mask_m = wd;
    @(negedge clk);
    check(rtag, rd_data, rd_m);
    check(itag, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, irq_m});
    evt_i = '0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle_read(input logic [1:0] rsel, input string tag);
    step('0, 1'b0, 2'd0, '0, 1'b1, rsel, tag, tag);
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    raw_m = '0; mask_m = '1; rd_m = '0; irq_m = 1'b0;
    rst = 1'b1;
    evt_i = 8'hFF; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h00;
    rd_en = 1'b1; rd_sel = 2'd1;
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports, reset wins over all strobes
    check("R1 rd_data", rd_data, '0);
    check("R1 irq", {{(N-1){1'b0}}, irq_o}, '0);
    evt_i = '0; wr_en = 1'b0; rd_en = 1'b0;
    rst = 1'b0;
    idle_read(2'd1, "R1 mask all ones");
    idle_read(2'd0, "R1 raw zero");

    // R2, R11: events recorded under full mask, irq stays low
    step(8'hFF, 1'b0, 2'd0, '0, 1'b0, 2'd0, "R2", "R11");
    idle_read(2'd0, "R2 raw set while masked");
    idle_read(2'd3, "R11 masked view zero");
    idle_read(2'd3, "R11 irq low");

    // R4: clear with zeros has no effect, then partial clear
    step('0, 1'b1, 2'd2, 8'h00, 1'b0, 2'd0, "R4", "R4");
    idle_read(2'd0, "R4 zero clear no effect");
    step('0, 1'b1, 2'd2, 8'h0F, 1'b0, 2'd0, "R4", "R4");
    idle_read(2'd0, "R4 partial clear");

    // R9: writes to raw and masked views ignored, clear view reads 0
    step('0, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, "R9", "R9");
    step('0, 1'b1, 2'd3, 8'h00, 1'b0, 2'd0, "R9", "R9");
    idle_read(2'd0, "R9 raw unchanged");
    idle_read(2'd1, "R9 mask unchanged");
    idle_read(2'd2, "R9 clear view reads zero");

    // R7, R8, R6: unmask bit 4 (transfer finished)
    step('0, 1'b1, 2'd1, 8'hEF, 1'b0, 2'd0, "R7", "R8");
    idle_read(2'd1, "R7 mask readback");
    idle_read(2'd3, "R6 masked view");
    idle_read(2'd3, "R8 irq asserted");

    // R5: event and clear on the same bit
    step(8'h10, 1'b1, 2'd2, 8'hFF, 1'b0, 2'd0, "R5", "R5");
    idle_read(2'd0, "R5 event wins");

    // R10: rd_data holds while rd_en low
    step(8'h01, 1'b0, 2'd0, '0, 1'b0, 2'd0, "R10 hold", "R8");
    step('0, 1'b0, 2'd0, '0, 1'b0, 2'd0, "R10 hold", "R8");

    // R3: flags survive idle cycles
    repeat (4) step('0, 1'b0, 2'd0, '0, 1'b0, 2'd0, "R3", "R3");
    idle_read(2'd0, "R3 sticky");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ev;
      logic [N-1:0] wd;
      logic         we;
      logic         re;
      ev = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) :
           ((($urandom % 8) == 0) ? N'($urandom) : '0);
      wd = N'($urandom);
      we = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      step(ev, we, 2'($urandom), wd, re, 2'($urandom), "R6 random read", "R8 random irq");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule